// File: doc/BRIEF.md
# Interrupt cause register unit

This unit collects interrupt causes for one group of up to 32 sources. A single-cycle event pulse on a source input latches the matching cause bit. Software sees the latched causes, a masked view of them and the current mask through a small word-addressed register port. Every cause bit is cleared in one of two ways, chosen bit by bit by a clear-mode register: writing a one to the bit, or reading the cause register. Software may also set cause bits itself, which makes interrupts easy to raise for test or signalling.

Masking uses two write-only ports, one that sets mask bits and one that clears them. Either can be used without a read-modify-write and without disturbing other bits. A registered group-pending output goes high whenever any unmasked cause bit is set, and feeds an aggregator outside this unit.

Accesses are one per cycle. Read data and its valid flag come out registered, one cycle after the read strobe.

Top module: `irq_cause_bank`

## Requirements
- R1: After synchronous reset, all cause bits and clear-mode bits are 0, all mask bits are 1, grp_pend is 0 and rvalid is 0.
- R2: A 1 on src_evt[i] for one cycle sets cause bit i on that clock edge. The bit stays set until it is cleared.
- R3: A write to the force register (byte offset 0x0C) sets every cause bit whose data bit is 1 and leaves the other bits as they are.
- R4: A write to the cause register (offset 0x04) clears every cause bit whose data bit is 1 and whose clear-mode bit is 0. Cause bits whose clear-mode bit is 1 are not changed by such a write.
- R5: A read of the cause register returns the value held before the read on rdata, with rvalid high, in the cycle after rd_en. On that same edge it clears every cause bit whose clear-mode bit is 1. Reading any other offset clears nothing.
- R6: When an event (from src_evt or a force write) and a clear reach the same cause bit in the same cycle, the bit ends up set.
- R7: A write to mask-set (0x14) sets the mask bits where the data is 1. A write to mask-clear (0x18) clears them. Reading the mask register (0x10) returns the current mask.
- R8: Reading the pending view (0x08) returns cause AND NOT mask. grp_pend is 1 exactly when that value is nonzero, and it follows the register state on the same clock edge.
- R9: The clear-mode register (0x00) is read and written whole, and a 1 in it selects clear-on-read for that bit. Reads of the write-only offsets (0x0C, 0x14, 0x18) and of unmapped offsets return zero. Bit i of every register belongs to source i, and address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | SRC_W | Event pulses, one per source |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | SRC_W | Write data |
| rdata | output | SRC_W | Registered read data |
| rvalid | output | 1 | rdata valid, one cycle after rd_en |
| grp_pend | output | 1 | Any unmasked cause bit set |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that rst is high from time zero until several edges have passed. The bench drives every access from a single task that raises exactly one strobe for one cycle on a falling edge, and it holds reset for four cycles before the first access. The stimulus does put events on the same cycle as a cause-register write or read, because the priority of events over clears is itself a requirement.

// File: rtl/irqcb_pkg.sv
package irqcb_pkg;

  localparam int unsigned SLOT_CNT = 7;
  localparam int unsigned SLOT_W   = 3;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_CMODE = 3'd0,
    SLOT_CAUSE = 3'd1,
    SLOT_PEND  = 3'd2,
    SLOT_FORCE = 3'd3,
    SLOT_MASK  = 3'd4,
    SLOT_MSET  = 3'd5,
    SLOT_MCLR  = 3'd6,
    SLOT_NONE  = 3'd7
  } slot_e;

  typedef struct packed {
    logic cmode_wr;
    logic cause_wr;
    logic force_wr;
    logic mset_wr;
    logic mclr_wr;
    logic cause_rd;
  } strobe_t;

endpackage

// File: rtl/irqcb_decode.sv
module irqcb_decode
  import irqcb_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output slot_e             slot
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] word_idx;
  logic             unused_low;

  assign word_idx   = addr[ADDR_W-1:2];
  assign unused_low = ^addr[1:0];

  always_comb begin
    if (word_idx < IDX_W'(SLOT_CNT)) slot = slot_e'(word_idx[SLOT_W-1:0]);
    else                             slot = SLOT_NONE;
  end

  always_comb begin
    strb          = '0;
    strb.cmode_wr = wr_en && (slot == SLOT_CMODE);
    strb.cause_wr = wr_en && (slot == SLOT_CAUSE);
    strb.force_wr = wr_en && (slot == SLOT_FORCE);
    strb.mset_wr  = wr_en && (slot == SLOT_MSET);
    strb.mclr_wr  = wr_en && (slot == SLOT_MCLR);
    strb.cause_rd = rd_en && (slot == SLOT_CAUSE);
  end

endmodule

// File: rtl/irqcb_cause_bank.sv
module irqcb_cause_bank #(
  parameter int unsigned SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src_evt,
  input  logic [SRC_W-1:0] wdata,
  input  logic             cmode_wr,
  input  logic             cause_wr,
  input  logic             force_wr,
  input  logic             cause_rd,
  output logic [SRC_W-1:0] cmode_q,
  output logic [SRC_W-1:0] cause_q,
  output logic [SRC_W-1:0] cause_d
);

  always_ff @(posedge clk) begin
    if (rst)           cmode_q <= '0;
    else if (cmode_wr) cmode_q <= wdata;
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    logic set_b;
    logic clr_b;
    logic nxt_b;
    assign set_b = src_evt[i] | (force_wr & wdata[i]);
    assign clr_b = (cause_wr & wdata[i] & ~cmode_q[i]) | (cause_rd & cmode_q[i]);
    assign nxt_b = set_b ? 1'b1 : (clr_b ? 1'b0 : cause_q[i]);
    assign cause_d[i] = nxt_b;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_d;
  end

  // R2: an event pulse is latched on the next edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|src_evt) |=> ((cause_q & $past(src_evt)) == $past(src_evt)));

  // R4: a write to the cause register spares clear-on-read bits
  a_r4_w1c_spares_cor: assert property (@(posedge clk) disable iff (rst)
    cause_wr |=> ((cause_q & $past(cause_q & cmode_q)) == $past(cause_q & cmode_q)));

  // R5: a cause read drops clear-on-read bits with no event on them
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    cause_rd |=> ((cause_q & $past(cmode_q & ~src_evt)) == '0));

  // R6: an event beats a write-one clear on the same bit
  a_r6_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    cause_wr |=> ((cause_q & $past(src_evt & wdata)) == $past(src_evt & wdata)));

endmodule

// File: rtl/irqcb_mask_reg.sv
module irqcb_mask_reg #(
  parameter int unsigned SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] wdata,
  input  logic             mset_wr,
  input  logic             mclr_wr,
  output logic [SRC_W-1:0] mask_q,
  output logic [SRC_W-1:0] mask_d
);

  always_comb begin
    mask_d = mask_q;
    if (mset_wr) mask_d = mask_d | wdata;
    if (mclr_wr) mask_d = mask_d & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_d;
  end

  // R7: mask-set raises the written bits
  a_r7_mask_set: assert property (@(posedge clk) disable iff (rst)
    mset_wr && !mclr_wr |=> ((mask_q & $past(wdata)) == $past(wdata)));

  // R7: mask-clear drops the written bits
  a_r7_mask_clr: assert property (@(posedge clk) disable iff (rst)
    mclr_wr |=> ((mask_q & $past(wdata)) == '0));

endmodule

// File: rtl/irqcb_read_mux.sv
module irqcb_read_mux
  import irqcb_pkg::*;
#(
  parameter int unsigned SRC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  slot_e            slot,
  input  logic [SRC_W-1:0] cmode_q,
  input  logic [SRC_W-1:0] cause_q,
  input  logic [SRC_W-1:0] mask_q,
  output logic [SRC_W-1:0] rdata,
  output logic             rvalid
);

  logic [SRC_W-1:0] sel;

  always_comb begin
    unique case (slot)
      SLOT_CMODE: sel = cmode_q;
      SLOT_CAUSE: sel = cause_q;
      SLOT_PEND:  sel = cause_q & ~mask_q;
      SLOT_MASK:  sel = mask_q;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= sel;
    end
  end

  // R5: every read strobe yields a valid flag one cycle later
  a_r5_rvalid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irqcb_pkg::*;
#(
  parameter int unsigned SRC_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  src_evt,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_W-1:0]  wdata,
  output logic [SRC_W-1:0]  rdata,
  output logic              rvalid,
  output logic              grp_pend
);

  strobe_t          strb;
  slot_e            slot;
  logic [SRC_W-1:0] cmode_q;
  logic [SRC_W-1:0] cause_q;
  logic [SRC_W-1:0] cause_d;
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] mask_d;

  irqcb_decode #(.ADDR_W(ADDR_W)) dec_i (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .strb  (strb),
    .slot  (slot)
  );

  irqcb_cause_bank #(.SRC_W(SRC_W)) cause_i (
    .clk      (clk),
    .rst      (rst),
    .src_evt  (src_evt),
    .wdata    (wdata),
    .cmode_wr (strb.cmode_wr),
    .cause_wr (strb.cause_wr),
    .force_wr (strb.force_wr),
    .cause_rd (strb.cause_rd),
    .cmode_q  (cmode_q),
    .cause_q  (cause_q),
    .cause_d  (cause_d)
  );

  irqcb_mask_reg #(.SRC_W(SRC_W)) mask_i (
    .clk     (clk),
    .rst     (rst),
    .wdata   (wdata),
    .mset_wr (strb.mset_wr),
    .mclr_wr (strb.mclr_wr),
    .mask_q  (mask_q),
    .mask_d  (mask_d)
  );

  irqcb_read_mux #(.SRC_W(SRC_W)) rmux_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .slot    (slot),
    .cmode_q (cmode_q),
    .cause_q (cause_q),
    .mask_q  (mask_q),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) grp_pend <= 1'b0;
    else     grp_pend <= |(cause_d & ~mask_d);
  end

  // R1: reset state of the stored registers and output
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && cause_q == '0 && cmode_q == '0 && !grp_pend));

  // R8: the pending output tracks the unmasked causes
  a_r8_pend_level: assert property (@(posedge clk) disable iff (rst)
    grp_pend == (|(cause_q & ~mask_q)));

endmodule

// File: tb/irq_cause_bank_tb_top.sv
module irq_cause_bank_tb_top;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 8;
  localparam int unsigned AW = 5;
  localparam int unsigned WDOG = 150000;

  localparam logic [AW-1:0] A_CMODE = 5'h00;
  localparam logic [AW-1:0] A_CAUSE = 5'h04;
  localparam logic [AW-1:0] A_PEND  = 5'h08;
  localparam logic [AW-1:0] A_FORCE = 5'h0C;
  localparam logic [AW-1:0] A_MASK  = 5'h10;
  localparam logic [AW-1:0] A_MSET  = 5'h14;
  localparam logic [AW-1:0] A_MCLR  = 5'h18;
  localparam logic [AW-1:0] A_HOLE  = 5'h1C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  src_evt = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          rvalid;
  logic          grp_pend;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_bank #(.SRC_W(W), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .src_evt(src_evt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .grp_pend(grp_pend)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one access per call; the state is visible at the negedge it returns on
  task automatic acc(input bit w, input bit r, input logic [AW-1:0] a,
                     input logic [W-1:0] d, input logic [W-1:0] e);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; src_evt = e;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; src_evt = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    acc(1'b1, 1'b0, a, d, '0);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] q);
    acc(1'b0, 1'b1, a, '0, '0);
    q = rdata;
  endtask

  initial begin : wdog
    for (int n = 0; n < WDOG; n++) begin
      @(posedge clk);
      if (done) disable wdog;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] q;
    logic [W-1:0] q2;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 grp_pend", int'(grp_pend), 0);
    chk("R1 rvalid", int'(rvalid), 0);
    rd(A_MASK, q);  chk("R1 mask", int'(q), 8'hFF);
    chk("R1 rvalid after read", int'(rvalid), 1);
    rd(A_CAUSE, q); chk("R1 cause", int'(q), 0);
    rd(A_CMODE, q); chk("R1 cmode", int'(q), 0);

    // R3/R4 sweep: force each pattern, then write it back to clear
    for (int v = 0; v < 256; v++) begin
      wr(A_FORCE, W'(v));
      chk("R8 pend masked", int'(grp_pend), 0);
      rd(A_CAUSE, q); chk("R3 force sets", int'(q), v);
      rd(A_CAUSE, q); chk("R5 w1c bits survive read", int'(q), v);
      wr(A_CAUSE, W'(v));
      rd(A_CAUSE, q); chk("R4 write-one clears", int'(q), 0);
    end

    // R7/R8 sweep over mask patterns with all causes set
    for (int v = 0; v < 256; v++) begin
      wr(A_MSET, 8'hFF);
      wr(A_MCLR, W'(v));
      rd(A_MASK, q); chk("R7 mask value", int'(q), (~v) & 8'hFF);
      wr(A_FORCE, 8'hFF);
      chk("R8 grp_pend", int'(grp_pend), int'(v != 0));
      rd(A_PEND, q); chk("R8 pending view", int'(q), v);
      wr(A_CAUSE, 8'hFF);
      chk("R8 grp_pend after clear", int'(grp_pend), 0);
    end
    wr(A_MSET, 8'h0F);
    rd(A_MASK, q); chk("R7 mask set keeps others", int'(q), 8'h0F);
    wr(A_MCLR, 8'hFF);

    // R5/R9 sweep over clear-mode patterns
    for (int m = 0; m < 256; m++) begin
      wr(A_CMODE, W'(m));
      rd(A_CMODE, q); chk("R9 cmode readback", int'(q), m);
      wr(A_FORCE, 8'hFF);
      rd(A_CAUSE, q); chk("R5 read returns old value", int'(q), 8'hFF);
      rd(A_CAUSE, q); chk("R5 read clears cor bits", int'(q), (~m) & 8'hFF);
      wr(A_CAUSE, 8'hFF);
      rd(A_CAUSE, q); chk("R4 all clear", int'(q), 0);
      wr(A_FORCE, 8'hFF);
      wr(A_CAUSE, 8'hFF);
      rd(A_PEND, q); chk("R4 write spares cor bits", int'(q), m);
      rd(A_CAUSE, q); chk("R5 pend read clears nothing", int'(q), m);
      rd(A_CAUSE, q); chk("R5 second read empty", int'(q), 0);
    end

    // R2 event pulses, one source at a time then together
    wr(A_CMODE, 8'h00);
    for (int i = 0; i < int'(W); i++) begin
      acc(1'b0, 1'b0, A_HOLE, '0, W'(1 << i));
      rd(A_CAUSE, q); chk("R2 event latched", int'(q), 1 << i);
      wr(A_CAUSE, W'(1 << i));
    end
    acc(1'b0, 1'b0, A_HOLE, '0, 8'hA5);
    repeat (3) @(negedge clk);
    rd(A_CAUSE, q); chk("R2 events held", int'(q), 8'hA5);
    wr(A_CAUSE, 8'hFF);

    // R6 event wins over write-one clear and over read clear
    wr(A_FORCE, 8'h0F);
    acc(1'b1, 1'b0, A_CAUSE, 8'h0F, 8'h01);
    rd(A_CAUSE, q); chk("R6 event beats write clear", int'(q), 8'h01);
    wr(A_CAUSE, 8'h01);
    wr(A_CMODE, 8'hFF);
    wr(A_FORCE, 8'hFF);
    acc(1'b0, 1'b1, A_CAUSE, '0, 8'h80);
    chk("R6 read data before clear", int'(rdata), 8'hFF);
    rd(A_CAUSE, q); chk("R6 event beats read clear", int'(q), 8'h80);

    // R4 read-then-write-back clears exactly what was read
    wr(A_CMODE, 8'h00);
    wr(A_FORCE, 8'h33);
    rd(A_CAUSE, q);
    acc(1'b0, 1'b0, A_HOLE, '0, 8'h40);
    wr(A_CAUSE, q);
    rd(A_CAUSE, q2); chk("R4 write-back leaves new bit", int'(q2), 8'h40);
    wr(A_CAUSE, 8'h40);

    // R9 write-only, unmapped and low address bits
    wr(A_FORCE, 8'h5A);
    rd(A_FORCE, q); chk("R9 force reads zero", int'(q), 0);
    rd(A_MSET, q);  chk("R9 mset reads zero", int'(q), 0);
    rd(A_MCLR, q);  chk("R9 mclr reads zero", int'(q), 0);
    rd(A_HOLE, q);  chk("R9 hole reads zero", int'(q), 0);
    wr(A_HOLE, 8'hFF);
    rd(A_CAUSE | 5'h3, q); chk("R9 low bits ignored", int'(q), 8'h5A);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule